// File: doc/BRIEF.md
# Windowed channel multiplicity trigger

This block forms a trigger decision from a bank of discriminator hit lines. Every line is first qualified by its own enable mask. The block watches for rising edges on the qualified lines. The first fresh edge seen while the block is idle opens a coincidence window that is a programmable number of clock cycles long. Each channel that produces an edge inside the window is counted once.

When the window closes, the number of distinct channels that fired is compared against a programmable lower bound and a programmable upper bound, both inclusive. If the count lies inside that band, the trigger output pulses high for one cycle. Alongside the decision, the block drives a registered OR of all qualified hit lines, which serves as a fast, unconditioned hit indication.

Limits, window length and mask are sampled into shadow copies only while no window is open. Software can therefore rewrite them at any time without corrupting a window that is already in progress. The single-bit trigger is meant to feed one input of a downstream trigger-source selector.

Top module: `mult_window_trig`

## Requirements
- R1: A hit line whose mask bit is 1 is disabled: it opens no window, adds nothing to the count and does not reach the hit OR output. A mask bit of 0 enables the line.
- R2: `hit_or_o` is high in the cycle after any enabled hit line is high, and low in the cycle after all enabled lines are low (one register of latency).
- R3: A rising edge on an enabled line sampled at clock edge e0 while idle opens a window. The window accepts edges at clock edges e0 through e0+W-1, where W is the window length. The window closes at edge e0+W. An edge arriving on the closing edge is not counted in the closing window; instead it opens the next window at once.
- R4: A channel is counted at most once per window. A line held high counts only on its rising edge, so holding it high across later windows opens no new window.
- R5: After the window closes at edge e0+W, `trig_o` is high for exactly one cycle, only if lower <= count <= upper. Both bounds are inclusive. `trig_o` is low during the rest of an open window.
- R6: The count covers the full range from 1 to the channel count, 64 by default. It is zero-extended before it is compared with the 8-bit limits, so a count of 64 passes a lower bound of 64 and fails an upper bound of 63.
- R7: With a lower bound of 0, `trig_o` is high on every cycle in which the block is idle, because an empty count is then inside the band.
- R8: Changes to the limits, the window length or the mask made while a window is open do not change that window's length or its decision. They take effect from the next window.
- R9: The reset is synchronous and active high. During reset and in the cycle after it, `trig_o` and `hit_or_o` are low. Reset abandons any open window without a trigger pulse.
- R10: A window length of 0 behaves as a length of 1: only the opening edge is counted, and the decision appears two cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | N_CH (64) | Discriminator hit lines, one per channel |
| mask_i | input | N_CH (64) | Per-channel disable mask, 1 = channel ignored |
| lo_lim_i | input | LIM_W (8) | Inclusive lower multiplicity bound |
| hi_lim_i | input | LIM_W (8) | Inclusive upper multiplicity bound |
| win_len_i | input | LIM_W (8) | Window length in clock cycles, 0 treated as 1 |
| trig_o | output | 1 | Multiplicity trigger pulse |
| hit_or_o | output | 1 | Registered OR of the enabled hit lines |

## Verification
Two functions can fall on the same clock edge: one window closing with its multiplicity decision, and the next window opening on a fresh edge. The bench provokes this by placing a second channel's rising edge exactly on the closing edge. With a band of exactly one channel, it expects two separate single-cycle pulses. A pulse missing, or merged into a count of two, shows that the late edge leaked into the first window or was dropped. A second collision is also provoked: a register rewrite in the middle of a window. Its result is judged by whether the window keeps its original length and band.

// File: rtl/mt_pkg.sv
package mt_pkg;

  // Window controller state.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } mt_state_e;

  localparam int unsigned MT_DEF_CH    = 64;
  localparam int unsigned MT_DEF_LIM_W = 8;

endpackage

// File: rtl/mt_chan_front.sv
module mt_chan_front #(
  parameter int unsigned N_CH = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] hit_i,
  input  logic [N_CH-1:0] mask_sh_i,
  input  logic            keep_seen_i,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] seen_o,
  output logic            or_o
);

  logic [N_CH-1:0] masked;
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] seen_q;
  logic            or_q;

  assign masked = hit_i & ~mask_sh_i;

  // Per-channel edge detector and seen latch.
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign rise_o[g] = masked[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        seen_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= masked[g];
        seen_q[g] <= (keep_seen_i & seen_q[g]) | rise_o[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) or_q <= 1'b0;
    else     or_q <= |masked;
  end

  assign seen_o = seen_q;
  assign or_o   = or_q;

  // R4: a seen flag may only become set from an edge in the previous cycle
  p_seen_from_edge_r4: assert property (@(posedge clk) disable iff (rst)
    ((seen_q & ~$past(seen_q) & ~$past(rise_o)) == '0));

endmodule

// File: rtl/mt_popcount.sv
module mt_popcount #(
  parameter int unsigned N_CH  = 64,
  parameter int unsigned CNT_W = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0]  vec_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end

endmodule

// File: rtl/mt_window_ctrl.sv
module mt_window_ctrl
  import mt_pkg::*;
#(
  parameter int unsigned N_CH  = 64,
  parameter int unsigned LIM_W = 8,
  parameter int unsigned CNT_W = $clog2(N_CH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  mask_i,
  input  logic [LIM_W-1:0] lo_i,
  input  logic [LIM_W-1:0] hi_i,
  input  logic [LIM_W-1:0] win_i,
  input  logic             any_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [N_CH-1:0]  mask_sh_o,
  output logic             keep_seen_o,
  output logic             trig_o
);

  localparam int unsigned CMP_W = (LIM_W > CNT_W) ? LIM_W : CNT_W;

  mt_state_e        st_q;
  logic [LIM_W-1:0] down_q;
  logic [LIM_W-1:0] lo_sh, hi_sh;
  logic [N_CH-1:0]  mask_sh;
  logic             trig_q;

  logic             closing, free;
  logic [LIM_W-1:0] win_m1;
  logic [CNT_W-1:0] eval_cnt;
  logic [CMP_W-1:0] cnt_x, lo_x, hi_x;
  logic             in_band;

  assign closing     = (st_q == ST_OPEN) && (down_q == '0);
  assign free        = (st_q == ST_IDLE) || closing;
  assign keep_seen_o = (st_q == ST_OPEN) && (down_q != '0);
  assign win_m1      = (win_i == '0) ? '0 : (win_i - LIM_W'(1));

  // Idle evaluates an empty count; closing evaluates the accumulated one.
  assign eval_cnt = closing ? cnt_i : '0;
  assign cnt_x    = CMP_W'(eval_cnt);
  assign lo_x     = CMP_W'(lo_sh);
  assign hi_x     = CMP_W'(hi_sh);
  assign in_band  = (cnt_x >= lo_x) && (cnt_x <= hi_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      down_q  <= '0;
      lo_sh   <= LIM_W'(1);
      hi_sh   <= '1;
      mask_sh <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= free && in_band;
      if (free) begin
        lo_sh   <= lo_i;
        hi_sh   <= hi_i;
        mask_sh <= mask_i;
        if (any_rise_i) begin
          st_q   <= ST_OPEN;
          down_q <= win_m1;
        end else begin
          st_q   <= ST_IDLE;
        end
      end else begin
        down_q <= down_q - LIM_W'(1);
      end
    end
  end

  assign mask_sh_o = mask_sh;
  assign trig_o    = trig_q;

  // R3: an open window counts down one step per cycle
  p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPEN && down_q != '0) |=>
      (st_q == ST_OPEN && down_q == $past(down_q) - LIM_W'(1)));

  // R8: configuration shadows are frozen inside an open window
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPEN && down_q != '0) |=>
      ($stable(lo_sh) && $stable(hi_sh) && $stable(mask_sh)));

  // R5: no pulse while the window is still accepting edges
  p_quiet_inside_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPEN && down_q != '0) |=> !trig_q);

endmodule

// File: rtl/mult_window_trig.sv
module mult_window_trig #(
  parameter int unsigned N_CH  = 64,
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  hit_i,
  input  logic [N_CH-1:0]  mask_i,
  input  logic [LIM_W-1:0] lo_lim_i,
  input  logic [LIM_W-1:0] hi_lim_i,
  input  logic [LIM_W-1:0] win_len_i,
  output logic             trig_o,
  output logic             hit_or_o
);

  localparam int unsigned CNT_W = $clog2(N_CH + 1);

  logic [N_CH-1:0]  mask_sh;
  logic [N_CH-1:0]  rise;
  logic [N_CH-1:0]  seen;
  logic             keep_seen;
  logic [CNT_W-1:0] cnt;

  mt_chan_front #(.N_CH(N_CH)) u_front (
    .clk         (clk),
    .rst         (rst),
    .hit_i       (hit_i),
    .mask_sh_i   (mask_sh),
    .keep_seen_i (keep_seen),
    .rise_o      (rise),
    .seen_o      (seen),
    .or_o        (hit_or_o)
  );

  mt_popcount #(.N_CH(N_CH), .CNT_W(CNT_W)) u_pop (
    .vec_i (seen),
    .cnt_o (cnt)
  );

  mt_window_ctrl #(.N_CH(N_CH), .LIM_W(LIM_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mask_i      (mask_i),
    .lo_i        (lo_lim_i),
    .hi_i        (hi_lim_i),
    .win_i       (win_len_i),
    .any_rise_i  (|rise),
    .cnt_i       (cnt),
    .mask_sh_o   (mask_sh),
    .keep_seen_o (keep_seen),
    .trig_o      (trig_o)
  );

  // R2: the OR output stays low after a cycle with no hit line high
  p_or_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(|hit_i) |-> !hit_or_o);

endmodule

// File: tb/mult_window_trig_tb_top.sv
module mult_window_trig_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] hit_i = '0;
  logic [63:0] mask_i = '0;
  logic [7:0]  lo_lim_i = 8'd1;
  logic [7:0]  hi_lim_i = 8'd255;
  logic [7:0]  win_len_i = 8'd4;
  logic        trig_o, hit_or_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mult_window_trig dut_i (
    .clk(clk), .rst(rst), .hit_i(hit_i), .mask_i(mask_i),
    .lo_lim_i(lo_lim_i), .hi_lim_i(hi_lim_i), .win_len_i(win_len_i),
    .trig_o(trig_o), .hit_or_o(hit_or_o)
  );

  typedef struct packed {
    logic [63:0] mask;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  win;
    logic [7:0]  d;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{64'h0, 64'h1, 64'h0, 8'd1, 8'd4, 8'd4, 8'd0, 1'b1},            // R5 single
    '{64'h0, 64'h1, 64'h2, 8'd2, 8'd4, 8'd4, 8'd3, 1'b1},            // R3 last slot
    '{64'h0, 64'h1, 64'h2, 8'd2, 8'd4, 8'd4, 8'd4, 1'b0},            // R3 too late
    '{64'h0, 64'hF, 64'h0, 8'd1, 8'd3, 8'd2, 8'd0, 1'b0},            // R5 over hi
    '{64'h0, 64'hF, 64'h0, 8'd1, 8'd4, 8'd2, 8'd0, 1'b1},            // R5 hi inclusive
    '{64'h0, 64'hF, 64'h0, 8'd4, 8'd8, 8'd2, 8'd0, 1'b1},            // R5 lo inclusive
    '{64'h0, 64'hF, 64'h0, 8'd5, 8'd8, 8'd2, 8'd0, 1'b0},            // R5 under lo
    '{64'h3, 64'hF, 64'h0, 8'd3, 8'd3, 8'd3, 8'd0, 1'b0},            // R1 masked
    '{64'h3, 64'hF, 64'h0, 8'd2, 8'd2, 8'd3, 8'd0, 1'b1},            // R1 masked
    '{64'h0, {64{1'b1}}, 64'h0, 8'd64, 8'd255, 8'd1, 8'd0, 1'b1},    // R6 full
    '{64'h0, {64{1'b1}}, 64'h0, 8'd1, 8'd63, 8'd1, 8'd0, 1'b0},      // R6 full over
    '{64'h0, 64'h1, 64'h20, 8'd2, 8'd2, 8'd0, 8'd1, 1'b0},           // R10 late
    '{64'h0, 64'h1, 64'h0, 8'd1, 8'd1, 8'd0, 8'd0, 1'b1},            // R10 single
    '{64'h0, 64'h8000_0000_0000_0000, 64'h1_0000_0000, 8'd2, 8'd2, 8'd255, 8'd200, 1'b1} // R3 long
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic setcfg(input logic [63:0] m, input logic [7:0] lo,
                        input logic [7:0] hi, input logic [7:0] w);
    mask_i = m; lo_lim_i = lo; hi_lim_i = hi; win_len_i = w;
    hit_i = '0;
    repeat (3) tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int weff;
    bit seen_pulse;
    tick();
    chk("R9 reset trig", trig_o, 1'b0);
    chk("R9 reset or", hit_or_o, 1'b0);
    tick();
    rst = 1'b0;
    tick();
    chk("R9 after reset trig", trig_o, 1'b0);
    chk("R9 after reset or", hit_or_o, 1'b0);

    // Table of vectors
    for (int v = 0; v < NV; v++) begin
      setcfg(VECS[v].mask, VECS[v].lo, VECS[v].hi, VECS[v].win);
      weff = (VECS[v].win == 0) ? 1 : int'(VECS[v].win);
      hit_i = VECS[v].a;
      for (int k = 1; k <= weff + 1; k++) begin
        tick();
        if (k == int'(VECS[v].d) && VECS[v].b != 0) hit_i = VECS[v].a | VECS[v].b;
        if (k == weff) chk($sformatf("R5 vec%0d early", v), trig_o, 1'b0);
        if (k == weff + 1) chk($sformatf("R3 R5 vec%0d result", v), trig_o, VECS[v].exp);
      end
      tick();
      chk($sformatf("R5 vec%0d one cycle", v), trig_o, 1'b0);
      hit_i = '0;
      repeat (2 * weff + 6) tick();
    end

    // R7: lower bound of zero
    setcfg('0, 8'd0, 8'd255, 8'd4);
    chk("R7 idle high", trig_o, 1'b1);
    tick();
    chk("R7 idle high again", trig_o, 1'b1);
    hit_i = 64'h1;
    tick(); tick();
    chk("R7 low while open", trig_o, 1'b0);
    repeat (3) tick();
    chk("R7 close in band", trig_o, 1'b1);
    hit_i = '0;
    lo_lim_i = 8'd1;
    repeat (10) tick();

    // R4: held level is not recounted
    setcfg('0, 8'd1, 8'd1, 8'd3);
    hit_i = 64'h1;
    repeat (4) tick();
    chk("R4 first window", trig_o, 1'b1);
    seen_pulse = 1'b0;
    for (int k = 0; k < 12; k++) begin
      tick();
      if (trig_o) seen_pulse = 1'b1;
    end
    chk("R4 held level no retrigger", seen_pulse, 1'b0);
    hit_i = '0;
    repeat (4) tick();

    // R8: rewrite during an open window
    setcfg('0, 8'd1, 8'd5, 8'd6);
    hit_i = 64'h3;
    tick();
    lo_lim_i = 8'd3; win_len_i = 8'd1;
    tick();
    chk("R8 length kept", trig_o, 1'b0);
    repeat (5) tick();
    chk("R8 old band used", trig_o, 1'b1);
    hit_i = '0;
    repeat (10) tick();
    hit_i = 64'h3;
    repeat (2) tick();
    chk("R8 new config next window", trig_o, 1'b0);
    hit_i = '0;
    repeat (6) tick();

    // R3: close and open on the same edge
    setcfg('0, 8'd1, 8'd1, 8'd2);
    hit_i = 64'h1;
    tick(); tick();
    hit_i = 64'h3;
    tick();
    chk("R3 first of pair", trig_o, 1'b1);
    tick();
    chk("R3 gap between pair", trig_o, 1'b0);
    tick();
    chk("R3 second of pair", trig_o, 1'b1);
    hit_i = '0;
    repeat (6) tick();

    // R1 and R2: mask and OR output
    setcfg(64'h80, 8'd1, 8'd255, 8'd2);
    hit_i = 64'h80;
    tick();
    chk("R1 masked or", hit_or_o, 1'b0);
    repeat (3) tick();
    chk("R1 masked no trigger", trig_o, 1'b0);
    hit_i = 64'h180;
    tick();
    chk("R2 or high", hit_or_o, 1'b1);
    hit_i = '0;
    tick();
    chk("R2 or low", hit_or_o, 1'b0);
    repeat (6) tick();

    // R9: reset in the middle of a window
    setcfg('0, 8'd1, 8'd1, 8'd4);
    hit_i = 64'h1;
    tick(); tick();
    rst = 1'b1;
    hit_i = '0;
    tick();
    chk("R9 reset trig", trig_o, 1'b0);
    chk("R9 reset or", hit_or_o, 1'b0);
    rst = 1'b0;
    seen_pulse = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (trig_o) seen_pulse = 1'b1;
    end
    chk("R9 abandoned window silent", seen_pulse, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule